// File: doc/BRIEF.md
# Link Training Settings Writer

This block turns one training step of a serial display link into the exact series of byte writes that the sink's configuration registers expect. A single-cycle apply command carries the per-lane drive levels (voltage swing, pre-emphasis, post-cursor), the number of active lanes, the link rate code, the sink's revision byte and the training pattern to send. The block captures these values and presents one write at a time on an address/data port with a valid/ready handshake.

The writes always come in the same order. First come the drive bytes, one per lane. Next come the packed post-cursor bytes, but only for newer sinks at the top rate. Last comes the pattern byte. A write that comes back with an error stops the sequence and is reported. The AUX channel that carries the writes and any PHY adjustment are handled elsewhere.

The controller has six states:
- IDLE waits for apply.
- DRIVE sends the per-lane drive bytes.
- POST sends the post-cursor bytes.
- PATTERN sends the pattern byte.
- DONE lasts one cycle and marks success.
- FAIL lasts one cycle and marks an error.

The transitions are:
- apply-accept: IDLE to DRIVE.
- drive-to-post: leaves DRIVE after the last lane's byte is accepted and post-cursor bytes are due.
- drive-to-pattern: leaves DRIVE after the last lane's byte is accepted and post-cursor bytes are not due.
- post-to-pattern: leaves POST after the last post-cursor byte is accepted.
- pattern-complete: PATTERN to DONE.
- write-error: from any writing state to FAIL.
- return: DONE or FAIL back to IDLE.

Top module: `lt_settings_writer`

## Requirements
- R1: After an accepted apply, the first writes are the drive bytes, one per active lane, in lane order. Lane i goes to address 0x103 + i, so the number of drive bytes equals the lane count (1, 2 or 4).
- R2: Each drive byte carries that lane's swing level in bits [2:0] and its pre-emphasis level in bits [4:3]. All other bits are zero. Lane i's levels come from bits [2i+1:2i] of the swing and pre-emphasis inputs.
- R3: Post-cursor bytes are sent only when the revision byte is 0x12 or higher and the rate code equals 0x14 (the top rate). Otherwise, the pattern byte follows the drive bytes directly.
- R4: When post-cursor bytes are sent, their count is the lane count halved and rounded up. Byte j goes to address 0x10F + j. Lane i's 2-bit level (post-cursor input bits [2i+1:2i]) sits in byte i/2, at bit 0 for an even lane and at bit 4 for an odd lane. Inactive lanes read as zero.
- R5: The last write goes to address 0x102. Its data is the pattern code (0 off, 1, 2 or 3 for the three training patterns) in bits [1:0], with bit 5 set whenever the code is not 0.
- R6: A presented write keeps its address and data until ready is high. Each write is accepted exactly once, and stalls do not change the sequence.
- R7: When a write is accepted with the error input high, no further writes are presented, error is high for one cycle, and done does not pulse.
- R8: An apply that arrives while a sequence is running or finishing is ignored. It neither changes the writes in flight nor starts a second sequence.
- R9: Done is high for exactly one cycle, in the cycle after the pattern write is accepted without error.
- R10: After reset, no write is presented and done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| apply_i | input | 1 | Single-cycle start command |
| lane_cnt_i | input | 3 | Active lane count (1, 2 or 4) |
| rate_i | input | 8 | Link rate code |
| rev_i | input | 8 | Sink revision byte |
| pattern_i | input | 2 | Training pattern code |
| swing_i | input | 8 | Per-lane voltage swing levels, 2 bits per lane |
| preemph_i | input | 8 | Per-lane pre-emphasis levels, 2 bits per lane |
| postc_i | input | 8 | Per-lane post-cursor levels, 2 bits per lane |
| wr_valid_o | output | 1 | Write presented |
| wr_addr_o | output | 20 | Register address of the presented write |
| wr_data_o | output | 8 | Data byte of the presented write |
| wr_ready_i | input | 1 | Write accepted this cycle |
| wr_err_i | input | 1 | The accepted write failed |
| done_o | output | 1 | Sequence completed (one-cycle pulse) |
| error_o | output | 1 | Sequence aborted (one-cycle pulse) |

## Verification
Two things can land in the same cycle: completion of the pattern write and an error report on that same write. The correct outcome is that the error wins. The bench provokes this by flagging an error on the final pattern write. It then requires one error pulse, no done pulse, and no write after the failing one.

A second overlap is an apply that arrives while a sequence is running. The bench sends this second apply with different lane settings in the middle of a four-lane burst. It then checks that the recorded writes match the first command exactly and that done pulses only once.

// File: rtl/lt_wr_pkg.sv
package lt_wr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DRIVE,
        S_POST,
        S_PAT,
        S_DONE,
        S_FAIL
    } wr_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/lt_cmd_latch.sv
module lt_cmd_latch #(
    parameter int          LANES_MAX = 4,
    parameter int          LVL_W     = 2,
    parameter int          PC_W      = 2,
    parameter int          RATE_W    = 8,
    parameter int          REV_W     = 8,
    parameter logic [7:0]  REV_MIN   = 8'h12,
    parameter logic [7:0]  TOP_RATE  = 8'h14,
    localparam int         LCNT_W    = $clog2(LANES_MAX + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [LCNT_W-1:0]          lane_cnt,
    input  logic [RATE_W-1:0]          rate,
    input  logic [REV_W-1:0]           rev,
    input  logic [1:0]                 pattern,
    input  logic [LANES_MAX*LVL_W-1:0] swing,
    input  logic [LANES_MAX*LVL_W-1:0] preemph,
    input  logic [LANES_MAX*PC_W-1:0]  postc,
    output logic [LCNT_W-1:0]          lanes_q,
    output logic [LANES_MAX*LVL_W-1:0] swing_q,
    output logic [LANES_MAX*LVL_W-1:0] pre_q,
    output logic [LANES_MAX*PC_W-1:0]  post_q,
    output logic [1:0]                 pat_q,
    output logic                       post_en_q
);

    logic [LCNT_W-1:0] lanes_fix;
    logic              post_due;

    // Clamp a lane count outside 1..LANES_MAX so the burst always ends.
    always_comb begin
        if (lane_cnt == '0) begin
            lanes_fix = LCNT_W'(1);
        end else if (lane_cnt > LCNT_W'(LANES_MAX)) begin
            lanes_fix = LCNT_W'(LANES_MAX);
        end else begin
            lanes_fix = lane_cnt;
        end
    end

    // Post-cursor bytes are due only for newer sinks at the top rate (R3).
    assign post_due = (rev >= REV_W'(REV_MIN)) && (rate == RATE_W'(TOP_RATE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lanes_q   <= LCNT_W'(1);
            swing_q   <= '0;
            pre_q     <= '0;
            post_q    <= '0;
            pat_q     <= '0;
            post_en_q <= 1'b0;
        end else if (load) begin
            lanes_q   <= lanes_fix;
            swing_q   <= swing;
            pre_q     <= preemph;
            post_q    <= postc;
            pat_q     <= pattern;
            post_en_q <= post_due;
        end
    end

endmodule

// File: rtl/lt_seq_fsm.sv
module lt_seq_fsm
    import lt_wr_pkg::*;
#(
    parameter int  LANES_MAX = 4,
    localparam int LCNT_W    = $clog2(LANES_MAX + 1),
    localparam int IDX_W     = (LANES_MAX > 1) ? $clog2(LANES_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  logic [LCNT_W-1:0] lanes_q,
    input  logic              post_en_q,
    input  logic              wr_ready,
    input  logic              wr_err,
    output logic              load,
    output wr_state_e         phase,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_valid,
    output logic              done,
    output logic              error
);

    wr_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              fire;
    logic [LCNT_W-1:0] idx_p1;
    logic [LCNT_W-1:0] n_post;
    logic              last_drive;
    logic              last_post;

    assign fire       = wr_valid && wr_ready;
    assign idx_p1     = LCNT_W'(idx_q) + LCNT_W'(1);
    assign n_post     = LCNT_W'((LCNT_W'(lanes_q) + LCNT_W'(1)) >> 1);
    assign last_drive = (idx_p1 == lanes_q);
    assign last_post  = (idx_p1 == n_post);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_IDLE: begin
                idx_d = '0;
                if (apply) begin
                    state_d = S_DRIVE;            // apply-accept
                end
            end
            S_DRIVE: begin
                if (fire) begin
                    if (wr_err) begin
                        state_d = S_FAIL;         // write-error
                    end else if (last_drive) begin
                        idx_d   = '0;
                        state_d = post_en_q ? S_POST : S_PAT;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            S_POST: begin
                if (fire) begin
                    if (wr_err) begin
                        state_d = S_FAIL;
                    end else if (last_post) begin
                        idx_d   = '0;
                        state_d = S_PAT;          // post-to-pattern
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            S_PAT: begin
                if (fire) begin
                    state_d = wr_err ? S_FAIL : S_DONE;
                end
            end
            S_DONE: state_d = S_IDLE;             // return
            S_FAIL: state_d = S_IDLE;             // return
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load     = 1'b0;
        wr_valid = 1'b0;
        done     = 1'b0;
        error    = 1'b0;
        unique case (state_q)
            S_IDLE:  load     = apply;
            S_DRIVE: wr_valid = 1'b1;
            S_POST:  wr_valid = 1'b1;
            S_PAT:   wr_valid = 1'b1;
            S_DONE:  done     = 1'b1;
            S_FAIL:  error    = 1'b1;
            default: ;
        endcase
    end

    assign phase = state_q;
    assign idx   = idx_q;

endmodule

// File: rtl/lt_byte_fmt.sv
module lt_byte_fmt
    import lt_wr_pkg::*;
#(
    parameter int             LANES_MAX  = 4,
    parameter int             LVL_W      = 2,
    parameter int             PC_W       = 2,
    parameter int             ADDR_W     = 20,
    parameter logic [19:0]    LANE0_ADDR = 20'h103,
    parameter logic [19:0]    SET2_ADDR  = 20'h10F,
    parameter logic [19:0]    PAT_ADDR   = 20'h102,
    parameter int             PE_LSB     = 3,
    parameter int             SCR_BIT    = 5,
    parameter int             ODD_LSB    = 4,
    localparam int            LCNT_W     = $clog2(LANES_MAX + 1),
    localparam int            IDX_W      = (LANES_MAX > 1) ? $clog2(LANES_MAX) : 1,
    localparam int            NPB        = (LANES_MAX + 1) / 2
) (
    input  wr_state_e                  phase,
    input  logic [IDX_W-1:0]           idx,
    input  logic [LCNT_W-1:0]          lanes_q,
    input  logic [LANES_MAX*LVL_W-1:0] swing_q,
    input  logic [LANES_MAX*LVL_W-1:0] pre_q,
    input  logic [LANES_MAX*PC_W-1:0]  post_q,
    input  logic [1:0]                 pat_q,
    output logic [ADDR_W-1:0]          addr,
    output logic [BYTE_W-1:0]          data
);

    logic [BYTE_W-1:0] drv_b  [LANES_MAX];
    logic [BYTE_W-1:0] post_b [NPB];
    logic [BYTE_W-1:0] pat_b;
    logic [BYTE_W-1:0] drv_sel;
    logic [BYTE_W-1:0] post_sel;

    // One drive byte per lane: swing at bit 0, pre-emphasis at PE_LSB (R2)
    for (genvar g = 0; g < LANES_MAX; g++) begin : g_drv
        always_comb begin
            drv_b[g] = '0;
            drv_b[g][LVL_W-1:0]          = swing_q[g*LVL_W +: LVL_W];
            drv_b[g][PE_LSB +: LVL_W]    = pre_q[g*LVL_W +: LVL_W];
        end
    end

    // Two lanes per post-cursor byte, inactive lanes forced to zero (R4)
    for (genvar g = 0; g < NPB; g++) begin : g_post
        always_comb begin
            post_b[g] = '0;
            if (LCNT_W'(2*g) < lanes_q) begin
                post_b[g][PC_W-1:0] = post_q[(2*g)*PC_W +: PC_W];
            end
            if ((2*g + 1 < LANES_MAX) && (LCNT_W'(2*g + 1) < lanes_q)) begin
                post_b[g][ODD_LSB +: PC_W] = post_q[((2*g + 1) % LANES_MAX)*PC_W +: PC_W];
            end
        end
    end

    // Pattern byte with scrambling-disable whenever a pattern is active (R5)
    always_comb begin
        pat_b         = BYTE_W'(pat_q);
        pat_b[SCR_BIT] = (pat_q != 2'd0);
    end

    always_comb begin
        drv_sel = '0;
        for (int i = 0; i < LANES_MAX; i++) begin
            if (idx == IDX_W'(i)) begin
                drv_sel = drv_b[i];
            end
        end
        post_sel = '0;
        for (int j = 0; j < NPB; j++) begin
            if (idx == IDX_W'(j)) begin
                post_sel = post_b[j];
            end
        end
    end

    always_comb begin
        addr = ADDR_W'(PAT_ADDR);
        data = pat_b;
        unique case (phase)
            S_DRIVE: begin
                addr = ADDR_W'(LANE0_ADDR) + ADDR_W'(idx);
                data = drv_sel;
            end
            S_POST: begin
                addr = ADDR_W'(SET2_ADDR) + ADDR_W'(idx);
                data = post_sel;
            end
            default: begin
                addr = ADDR_W'(PAT_ADDR);
                data = pat_b;
            end
        endcase
    end

endmodule

// File: rtl/lt_settings_writer.sv
module lt_settings_writer
    import lt_wr_pkg::*;
#(
    parameter int          LANES_MAX  = 4,
    parameter int          LVL_W      = 2,
    parameter int          PC_W       = 2,
    parameter int          RATE_W     = 8,
    parameter int          REV_W      = 8,
    parameter int          ADDR_W     = 20,
    parameter logic [7:0]  REV_MIN    = 8'h12,
    parameter logic [7:0]  TOP_RATE   = 8'h14,
    parameter logic [19:0] LANE0_ADDR = 20'h103,
    parameter logic [19:0] SET2_ADDR  = 20'h10F,
    parameter logic [19:0] PAT_ADDR   = 20'h102,
    localparam int         LCNT_W     = $clog2(LANES_MAX + 1),
    localparam int         IDX_W      = (LANES_MAX > 1) ? $clog2(LANES_MAX) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       apply_i,
    input  logic [LCNT_W-1:0]          lane_cnt_i,
    input  logic [RATE_W-1:0]          rate_i,
    input  logic [REV_W-1:0]           rev_i,
    input  logic [1:0]                 pattern_i,
    input  logic [LANES_MAX*LVL_W-1:0] swing_i,
    input  logic [LANES_MAX*LVL_W-1:0] preemph_i,
    input  logic [LANES_MAX*PC_W-1:0]  postc_i,
    output logic                       wr_valid_o,
    output logic [ADDR_W-1:0]          wr_addr_o,
    output logic [7:0]                 wr_data_o,
    input  logic                       wr_ready_i,
    input  logic                       wr_err_i,
    output logic                       done_o,
    output logic                       error_o
);

    logic                       load;
    wr_state_e                  phase;
    logic [IDX_W-1:0]           idx;
    logic [LCNT_W-1:0]          lanes_q;
    logic [LANES_MAX*LVL_W-1:0] swing_q;
    logic [LANES_MAX*LVL_W-1:0] pre_q;
    logic [LANES_MAX*PC_W-1:0]  post_q;
    logic [1:0]                 pat_q;
    logic                       post_en_q;

    lt_cmd_latch #(
        .LANES_MAX (LANES_MAX),
        .LVL_W     (LVL_W),
        .PC_W      (PC_W),
        .RATE_W    (RATE_W),
        .REV_W     (REV_W),
        .REV_MIN   (REV_MIN),
        .TOP_RATE  (TOP_RATE)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .lane_cnt  (lane_cnt_i),
        .rate      (rate_i),
        .rev       (rev_i),
        .pattern   (pattern_i),
        .swing     (swing_i),
        .preemph   (preemph_i),
        .postc     (postc_i),
        .lanes_q   (lanes_q),
        .swing_q   (swing_q),
        .pre_q     (pre_q),
        .post_q    (post_q),
        .pat_q     (pat_q),
        .post_en_q (post_en_q)
    );

    lt_seq_fsm #(
        .LANES_MAX (LANES_MAX)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply     (apply_i),
        .lanes_q   (lanes_q),
        .post_en_q (post_en_q),
        .wr_ready  (wr_ready_i),
        .wr_err    (wr_err_i),
        .load      (load),
        .phase     (phase),
        .idx       (idx),
        .wr_valid  (wr_valid_o),
        .done      (done_o),
        .error     (error_o)
    );

    lt_byte_fmt #(
        .LANES_MAX  (LANES_MAX),
        .LVL_W      (LVL_W),
        .PC_W       (PC_W),
        .ADDR_W     (ADDR_W),
        .LANE0_ADDR (LANE0_ADDR),
        .SET2_ADDR  (SET2_ADDR),
        .PAT_ADDR   (PAT_ADDR)
    ) u_fmt (
        .phase     (phase),
        .idx       (idx),
        .lanes_q   (lanes_q),
        .swing_q   (swing_q),
        .pre_q     (pre_q),
        .post_q    (post_q),
        .pat_q     (pat_q),
        .addr      (wr_addr_o),
        .data      (wr_data_o)
    );

endmodule

// File: rtl/lt_wr_checker.sv
module lt_wr_checker #(
    parameter int          ADDR_W   = 20,
    parameter logic [19:0] PAT_ADDR = 20'h102
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid_o,
    input logic              wr_ready_i,
    input logic              wr_err_i,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [7:0]        wr_data_o,
    input logic              done_o,
    input logic              error_o
);

    // R6: a stalled write holds address and data
    a_r6_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // R7: a failed write raises error and stops further writes
    a_r7_abort_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_ready_i && wr_err_i) |=> (error_o && !wr_valid_o && !done_o));

    // R7: done and error never together
    a_r7_excl_done_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    // R9: done lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: done follows an accepted, error-free pattern write
    a_r5_pattern_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_valid_o && wr_ready_i && !wr_err_i && (wr_addr_o == ADDR_W'(PAT_ADDR))));

endmodule

bind lt_settings_writer lt_wr_checker #(
    .ADDR_W   (ADDR_W),
    .PAT_ADDR (PAT_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_err_i   (wr_err_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o),
    .error_o    (error_o)
);

// File: tb/lt_settings_writer_tb.sv
`timescale 1ns/1ps
module lt_settings_writer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        apply_i = 1'b0;
    logic [2:0]  lane_cnt_i = 3'd1;
    logic [7:0]  rate_i = '0;
    logic [7:0]  rev_i = '0;
    logic [1:0]  pattern_i = '0;
    logic [7:0]  swing_i = '0;
    logic [7:0]  preemph_i = '0;
    logic [7:0]  postc_i = '0;
    logic        wr_valid_o;
    logic [19:0] wr_addr_o;
    logic [7:0]  wr_data_o;
    logic        wr_ready_i = 1'b0;
    logic        wr_err_i = 1'b0;
    logic        done_o;
    logic        error_o;

    always #2 clk = ~clk;   // 250 MHz

    lt_settings_writer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .apply_i    (apply_i),
        .lane_cnt_i (lane_cnt_i),
        .rate_i     (rate_i),
        .rev_i      (rev_i),
        .pattern_i  (pattern_i),
        .swing_i    (swing_i),
        .preemph_i  (preemph_i),
        .postc_i    (postc_i),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_ready_i (wr_ready_i),
        .wr_err_i   (wr_err_i),
        .done_o     (done_o),
        .error_o    (error_o)
    );

    int n_cmp = 0;
    int n_mis = 0;
    int cyc = 0;
    int nwr = 0;
    int ndone = 0;
    int nerr = 0;
    int err_at = -1;
    bit stall_en = 1'b0;
    bit finished = 1'b0;
    logic [19:0] log_a [16];
    logic [7:0]  log_d [16];

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_mis++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Sink model and monitor, all at the falling edge
    always @(negedge clk) begin
        bit rdy;
        cyc++;
        rdy = stall_en ? (cyc % 2 == 0) : 1'b1;
        wr_ready_i = rdy;
        wr_err_i   = rdy && wr_valid_o && (nwr == err_at);
        if (rst_n && wr_valid_o && rdy) begin
            if (nwr < 16) begin
                log_a[nwr] = wr_addr_o;
                log_d[nwr] = wr_data_o;
            end
            nwr++;
        end
        if (rst_n && done_o)  ndone++;
        if (rst_n && error_o) nerr++;
    end

    task automatic run_case(input string tag, input int lanes, input int rate, input int rev,
                            input int pat, input logic [7:0] sw, input logic [7:0] pe,
                            input logic [7:0] pc, input bit stall, input int eat,
                            input bit busy_apply);
        int ea [16];
        int ed [16];
        int n = 0;
        int exp_n;
        @(posedge clk);
        nwr = 0; ndone = 0; nerr = 0;
        stall_en = stall; err_at = eat;
        for (int i = 0; i < lanes; i++) begin
            ea[n] = 'h103 + i;
            ed[n] = ((sw >> (2*i)) & 3) | (((pe >> (2*i)) & 3) << 3);
            n++;
        end
        if (rev >= 'h12 && rate == 'h14) begin
            for (int j = 0; j < (lanes + 1) / 2; j++) begin
                int b = 0;
                for (int i = 0; i < lanes; i++)
                    if (i / 2 == j) b = b | (((pc >> (2*i)) & 3) << ((i % 2) * 4));
                ea[n] = 'h10F + j;
                ed[n] = b;
                n++;
            end
        end
        ea[n] = 'h102;
        ed[n] = pat | ((pat != 0) ? 32 : 0);
        n++;
        @(negedge clk);
        apply_i = 1'b1; lane_cnt_i = 3'(lanes); rate_i = 8'(rate); rev_i = 8'(rev);
        pattern_i = 2'(pat); swing_i = sw; preemph_i = pe; postc_i = pc;
        @(negedge clk);
        apply_i = 1'b0;
        if (busy_apply) begin
            @(negedge clk);
            apply_i = 1'b1; lane_cnt_i = 3'd1; pattern_i = 2'd0;
            swing_i = 8'hFF; preemph_i = 8'hFF; postc_i = 8'hFF;
            @(negedge clk);
            apply_i = 1'b0;
        end
        for (int k = 0; k < 100; k++) begin
            if (ndone + nerr > 0) break;
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
        exp_n = (eat >= 0) ? eat + 1 : n;
        check({tag, " write count"}, nwr, exp_n);
        for (int k = 0; k < exp_n && k < nwr && k < 16; k++) begin
            check({tag, " addr"}, int'(log_a[k]), ea[k]);
            check({tag, " data"}, int'(log_d[k]), ed[k]);
        end
        check({tag, " done pulses"}, ndone, (eat >= 0) ? 0 : 1);
        check({tag, " error pulses"}, nerr, (eat >= 0) ? 1 : 0);
        stall_en = 1'b0; err_at = -1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 valid after reset", int'(wr_valid_o), 0);
        check("R10 done after reset", int'(done_o), 0);
        check("R10 error after reset", int'(error_o), 0);
    endtask

    // R1 R2 R3 R4 R5 R9: four lanes, new sink, top rate
    task automatic t_four_lane_post();
        run_case("R1/R2/R4 4-lane post", 4, 'h14, 'h12, 1, 8'b00_11_10_01, 8'b01_10_11_00, 8'b11_01_10_10, 1'b0, -1, 1'b0);
    endtask

    // R3: old revision, top rate -> no post bytes
    task automatic t_old_rev();
        run_case("R3 old revision", 2, 'h14, 'h11, 2, 8'h0B, 8'h06, 8'hFF, 1'b0, -1, 1'b0);
    endtask

    // R3: new revision, lower rate -> no post bytes
    task automatic t_low_rate();
        run_case("R3 lower rate", 4, 'h0A, 'h14, 3, 8'hE4, 8'h1B, 8'hFF, 1'b0, -1, 1'b0);
    endtask

    // R4: one lane -> one post byte, odd field zero
    task automatic t_one_lane_post();
        run_case("R4 one lane", 1, 'h14, 'h14, 3, 8'h03, 8'h02, 8'hFF, 1'b0, -1, 1'b0);
    endtask

    // R5: disabled pattern has no scrambling bit
    task automatic t_pattern_off();
        run_case("R5 pattern off", 2, 'h14, 'h12, 0, 8'h05, 8'h0A, 8'h0D, 1'b0, -1, 1'b0);
    endtask

    // R6: stalled sink
    task automatic t_stall();
        run_case("R6 stall", 4, 'h14, 'h12, 2, 8'h1E, 8'hC3, 8'h9C, 1'b1, -1, 1'b0);
    endtask

    // R7: error mid-burst
    task automatic t_err_mid();
        run_case("R7 error mid", 4, 'h14, 'h12, 1, 8'h55, 8'hAA, 8'h33, 1'b0, 1, 1'b0);
    endtask

    // R7: error on the final pattern write, error wins over done
    task automatic t_err_last();
        run_case("R7 error last", 2, 'h14, 'h12, 2, 8'h09, 8'h06, 8'h0F, 1'b0, 3, 1'b0);
    endtask

    // R8: apply while busy is ignored
    task automatic t_busy_apply();
        run_case("R8 busy apply", 4, 'h14, 'h12, 3, 8'h27, 8'h72, 8'h4B, 1'b0, -1, 1'b1);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_cmp++; n_mis++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_four_lane_post();
        t_old_rev();
        t_low_rate();
        t_one_lane_post();
        t_pattern_off();
        t_stall();
        t_err_mid();
        t_err_last();
        t_busy_apply();
        t_four_lane_post();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

endmodule